// File: doc/BRIEF.md
# Repeating BCD Alarm Comparator

This block stores an alarm time as four BCD registers (second, minute, hour and day of month) and compares it with the current BCD time supplied by an external real-time counter. The counter also supplies a one-second tick. The comparison runs only on that tick. When the compared fields agree and the alarm is enabled, the block emits an interrupt pulse one clock cycle long.

Bit 7 of each alarm register is a "don't care" flag. The pattern of these flags selects how often the alarm repeats: monthly, daily, hourly, every minute or every second. Software writes the registers through a byte-wide port. A write whose BCD value is out of range for its field is dropped, and the register keeps its old contents. Reads are combinational and return the stored byte, including the flag bit.

Top module: `bcd_alarm_top`

## Requirements
- R1: Reset clears all four alarm registers to 0x00 and drives `irq` low.
- R2: Register select encoding: 0 = seconds, 1 = minutes, 2 = hours, 3 = date. A write to seconds or minutes is stored only when bits 3:0 are at most 9 and the value of bits 6:4 times ten plus bits 3:0 is at most 59. Otherwise the register is unchanged.
- R3: A write to hours is stored only when bits 3:0 are at most 9 and the value of bits 5:4 times ten plus bits 3:0 is at most 23. Otherwise the register is unchanged.
- R4: A write to date is stored only when bits 3:0 are at most 9 and the value of bits 5:4 times ten plus bits 3:0 is nonzero. Otherwise the register is unchanged.
- R5: An accepted write stores the whole byte. A read returns that stored byte, including the flag in bit 7.
- R6: With all four bit-7 flags clear, a tick fires only when date, hour, minute and second all match. Seconds and minutes compare bits 6:0; hours and date compare bits 5:0.
- R7: With only the date flag set, a tick fires when hour, minute and second match.
- R8: With only the date and hour flags set, a tick fires when minute and second match.
- R9: With the date, hour and minute flags set and the seconds flag clear, a tick fires when the second matches.
- R10: With any other flag pattern, every tick fires.
- R11: `irq` rises in the cycle after a firing tick and stays high for exactly one cycle after a single-cycle tick. Without a tick, `irq` stays low even when the time matches.
- R12: When `alarm_en` is low at the tick, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for both write and read |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Selected register contents |
| now_sec | input | 7 | Current second, BCD |
| now_min | input | 7 | Current minute, BCD |
| now_hour | input | 6 | Current hour, BCD |
| now_date | input | 6 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse at each second |
| alarm_en | input | 1 | Alarm interrupt enable |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The write checker is swept with all 256 byte values on each of the four registers. The bench reads each register back after every write, so the accepted and rejected values of every field are told apart, including nibbles above 9 and the boundaries 59, 23 and zero. The comparator is tried with all 16 flag patterns, and each pattern runs against five time vectors: an exact match and four vectors that each differ in one field. Whether a field mismatch blocks or allows the pulse shows which repeat mode each pattern chose. Separate cases drop the tick or the enable while the time matches, to show that both gate the pulse, and each pulse is checked to last exactly one cycle.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int MS_W     = 7;   // seconds / minutes BCD width
    localparam int HD_W     = 6;   // hours / date BCD width
    localparam int FLAG_BIT = BYTE_W - 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 2'd0,
        SEL_MIN  = 2'd1,
        SEL_HOUR = 2'd2,
        SEL_DATE = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MIN,
        RPT_SEC
    } rpt_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] date;
    } alarm_regs_t;

    function automatic logic bcd_in_range(input logic [3:0] tens,
                                          input logic [3:0] units,
                                          input int unsigned max_val,
                                          input logic need_nonzero);
        int unsigned val;
        val = int'(tens) * 10 + int'(units);
        return (units <= 4'd9) && (val <= max_val) && (!need_nonzero || val != 0);
    endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import bcd_alarm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [BYTE_W-1:0]       wr_data,
    output alarm_regs_t             regs
);
    alarm_regs_t regs_d, regs_q;
    logic        ok_ms, ok_hour, ok_date;

    always_comb begin
        ok_ms   = bcd_in_range({1'b0, wr_data[6:4]}, wr_data[3:0], 59, 1'b0);
        ok_hour = bcd_in_range({2'b00, wr_data[5:4]}, wr_data[3:0], 23, 1'b0);
        ok_date = bcd_in_range({2'b00, wr_data[5:4]}, wr_data[3:0], 39, 1'b1);
        regs_d  = regs_q;
        if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_SEC:  if (ok_ms)   regs_d.sec  = wr_data;
                SEL_MIN:  if (ok_ms)   regs_d.min  = wr_data;
                SEL_HOUR: if (ok_hour) regs_d.hour = wr_data;
                SEL_DATE: if (ok_date) regs_d.date = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    assert_sec_bcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.sec[3:0] <= 4'd9) && (regs_q.sec[6:4] <= 3'd5));
    assert_min_bcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.min[3:0] <= 4'd9) && (regs_q.min[6:4] <= 3'd5));
    assert_hour_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.hour[3:0] <= 4'd9) &&
        ((regs_q.hour[5:4] < 2'd2) || (regs_q.hour[3:0] <= 4'd3)));
    assert_date_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_q.date) |-> (regs_q.date[5:0] != 6'd0));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import bcd_alarm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MS_W-1:0] alm_sec,
    input  logic [MS_W-1:0] alm_min,
    input  logic [HD_W-1:0] alm_hour,
    input  logic [HD_W-1:0] alm_date,
    input  logic [3:0]      flags,      // {date, hour, min, sec}
    input  logic [MS_W-1:0] now_sec,
    input  logic [MS_W-1:0] now_min,
    input  logic [HD_W-1:0] now_hour,
    input  logic [HD_W-1:0] now_date,
    input  logic            sec_tick,
    input  logic            alarm_en,
    output logic            irq
);
    rpt_e rpt;
    logic eq_sec, eq_min, eq_hour, eq_date, hit;
    logic irq_d, irq_q;

    always_comb begin
        case (flags)
            4'b0000: rpt = RPT_MONTH;
            4'b1000: rpt = RPT_DAY;
            4'b1100: rpt = RPT_HOUR;
            4'b1110: rpt = RPT_MIN;
            default: rpt = RPT_SEC;
        endcase
        eq_sec  = (alm_sec  == now_sec);
        eq_min  = (alm_min  == now_min);
        eq_hour = (alm_hour == now_hour);
        eq_date = (alm_date == now_date);
        case (rpt)
            RPT_MONTH: hit = eq_date && eq_hour && eq_min && eq_sec;
            RPT_DAY:   hit = eq_hour && eq_min && eq_sec;
            RPT_HOUR:  hit = eq_min && eq_sec;
            RPT_MIN:   hit = eq_sec;
            default:   hit = 1'b1;
        endcase
        irq_d = sec_tick && alarm_en && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    assert_irq_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(sec_tick));
    assert_irq_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(alarm_en));
    assert_month_all_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(flags) == 4'b0000) |->
            ($past(now_sec) == $past(alm_sec) && $past(now_date) == $past(alm_date)));
endmodule

// File: rtl/bcd_alarm_top.sv
module bcd_alarm_top
    import bcd_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [MS_W-1:0]   now_sec,
    input  logic [MS_W-1:0]   now_min,
    input  logic [HD_W-1:0]   now_hour,
    input  logic [HD_W-1:0]   now_date,
    input  logic              sec_tick,
    input  logic              alarm_en,
    output logic              irq
);
    alarm_regs_t regs;
    logic [3:0]  flags;

    alarm_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (reg_sel),
        .wr_data (wr_data),
        .regs    (regs)
    );

    always_comb begin
        case (sel_e'(reg_sel))
            SEL_SEC:  rd_data = regs.sec;
            SEL_MIN:  rd_data = regs.min;
            SEL_HOUR: rd_data = regs.hour;
            default:  rd_data = regs.date;
        endcase
        flags = {regs.date[FLAG_BIT], regs.hour[FLAG_BIT],
                 regs.min[FLAG_BIT],  regs.sec[FLAG_BIT]};
    end

    alarm_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .alm_sec  (regs.sec[MS_W-1:0]),
        .alm_min  (regs.min[MS_W-1:0]),
        .alm_hour (regs.hour[HD_W-1:0]),
        .alm_date (regs.date[HD_W-1:0]),
        .flags    (flags),
        .now_sec  (now_sec),
        .now_min  (now_min),
        .now_hour (now_hour),
        .now_date (now_date),
        .sec_tick (sec_tick),
        .alarm_en (alarm_en),
        .irq      (irq)
    );
endmodule

// File: tb/bcd_alarm_top_tb_top.sv
module bcd_alarm_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [6:0] now_sec = 7'd0, now_min = 7'd0;
    logic [5:0] now_hour = 6'd0, now_date = 6'd0;
    logic       sec_tick = 1'b0, alarm_en = 1'b0;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    logic [7:0] shadow [4];

    always #5 clk = ~clk;

    bcd_alarm_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .now_sec(now_sec),
        .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
        .sec_tick(sec_tick), .alarm_en(alarm_en), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic bit accept(input int idx, input logic [7:0] v);
        int u, t, val;
        u = int'(v[3:0]);
        t = (idx < 2) ? int'(v[6:4]) : int'(v[5:4]);
        val = t * 10 + u;
        if (u > 9) return 0;
        case (idx)
            0, 1:    return val <= 59;
            2:       return val <= 23;
            default: return val != 0;
        endcase
    endfunction

    task automatic wr(input int idx, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = 2'(idx); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int idx, input string req);
        reg_sel = 2'(idx);
        #1;
        check(req, rd_data, shadow[idx]);
    endtask

    // One tick cycle, then sample irq at the following negedge and one later.
    task automatic tick_check(input bit tick, input bit en, input bit exp, input string req);
        @(negedge clk);
        sec_tick = tick; alarm_en = en;
        @(negedge clk);
        sec_tick = 1'b0;
        check(req, {7'd0, irq}, {7'd0, exp});
        @(negedge clk);
        check("R11 pulse width", {7'd0, irq}, 8'd0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
        // R1: reset state
        for (int i = 0; i < 4; i++) rd_check(i, "R1 reset value");
        check("R1 irq after reset", {7'd0, irq}, 8'd0);

        // R2/R3/R4/R5: exhaustive write sweep with readback
        for (int i = 0; i < 4; i++) begin
            for (int v = 0; v < 256; v++) begin
                wr(i, 8'(v));
                if (accept(i, 8'(v))) shadow[i] = 8'(v);
                case (i)
                    0, 1:    rd_check(i, "R2 sec/min write filter R5");
                    2:       rd_check(i, "R3 hour write filter R5");
                    default: rd_check(i, "R4 date write filter R5");
                endcase
            end
        end

        // Repeat modes: all 16 flag patterns x 5 time vectors
        for (int m = 0; m < 16; m++) begin
            bit fs, fm, fh, fd;
            fs = m[0]; fm = m[1]; fh = m[2]; fd = m[3];
            wr(0, {fs, 7'h30});
            wr(1, {fm, 7'h15});
            wr(2, {fh, 7'h08});
            wr(3, {fd, 7'h12});
            for (int p = 0; p < 5; p++) begin
                bit exp;
                string req;
                now_sec  = (p == 1) ? 7'h31 : 7'h30;
                now_min  = (p == 2) ? 7'h16 : 7'h15;
                now_hour = (p == 3) ? 6'h09 : 6'h08;
                now_date = (p == 4) ? 6'h13 : 6'h12;
                if (m == 0)       begin exp = (p == 0);                 req = "R6 monthly"; end
                else if (m == 8)  begin exp = (p == 0 || p == 4);       req = "R7 daily"; end
                else if (m == 12) begin exp = (p == 0 || p >= 3);       req = "R8 hourly"; end
                else if (m == 14) begin exp = (p != 1);                 req = "R9 per minute"; end
                else              begin exp = 1'b1;                     req = "R10 per second"; end
                tick_check(1'b1, 1'b1, exp, req);
            end
        end

        // R11: no tick, matching time -> no irq; R12: disabled -> no irq
        wr(0, 8'h45); wr(1, 8'h20); wr(2, 8'h13); wr(3, 8'h07);
        now_sec = 7'h45; now_min = 7'h20; now_hour = 6'h13; now_date = 6'h07;
        tick_check(1'b0, 1'b1, 1'b0, "R11 no tick");
        tick_check(1'b1, 1'b0, 1'b0, "R12 disabled");
        tick_check(1'b1, 1'b1, 1'b1, "R6 R11 monthly match fires");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule